// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the slave-side command engine of a byte-wide serial memory holding 16K x 8. A serial front end turns the bus wires into clock-synchronous events: a one-cycle pulse when chip select falls, a one-cycle pulse when it rises, and a strobe for each serial bit with the sampled input bit. After a select, the engine collects an 8-bit command. It then sets or clears its write-enable latch, returns the status byte, streams array contents back, or accepts data bytes for a page write. It returns read data one bit at a time on an output bit with its own output enable.

The storage array is a synchronous RAM that lives outside the block. The engine drives its address, write data and write strobe, and it receives read data one clock after it presents an address. Page data is held in an internal page buffer. When chip select rises on a clean byte boundary, the buffer is copied into the RAM during a busy period whose length is a parameter in clock cycles. During that period a protection unit answers, byte by byte, whether each address may be written. The same unit answers whether the status register may be written. The engine supplies it with the protection-level and pin-enable status bits.

Top module: `spimem_ctrl`

## Requirements
- R1: Command codes are matched with bit 3 ignored and bits 7..4 zero. The low three bits 110 set write enable, 100 clear write enable, 101 read status, 001 write status, 011 read array and 010 write array.
- R2: The status byte is laid out with bit 7 as pin-protect enable, bits 3..2 as protection level, bit 1 as write enable and bit 0 as busy, and bits 6..4 read 0. While a write cycle runs, the status byte reads 8'hFF. All bytes move most significant bit first.
- R3: After an unrecognised command, so_oe stays low and all further bits are ignored until the next chip-select fall.
- R4: Read and write commands take a 16-bit address, most significant byte first. Address bits 15..14 are ignored.
- R5: A read returns successive bytes while strobes continue, and the address steps up by one per byte and wraps from 14'h3FFF to 0.
- R6: During a write, the low six address bits step per data byte and wrap inside the 64-byte page. A later byte for the same slot replaces the earlier one.
- R7: A write is programmed only when chip select rises with no partial byte pending, at least one data byte received, and write enable set. A write sent while write enable is clear leaves the array and status unchanged.
- R8: A chip-select rise in the middle of a data byte programs nothing, starts no busy period, and leaves write enable as it was.
- R9: While busy, every command other than status read is ignored and so_oe stays low.
- R10: Write enable is clear after reset and is cleared when a write cycle ends. The busy period lasts WRITE_CYCLES clocks.
- R11: A byte whose address the protection unit rejects (prot_mem_ok low) is not written. A status write with prot_sr_ok low at the chip-select rise changes nothing.
- R12: so_oe is low after reset and on the cycle after every chip-select rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_fall | input | 1 | One-cycle pulse: chip select went low |
| cs_rise | input | 1 | One-cycle pulse: chip select went high |
| bit_stb | input | 1 | One-cycle pulse per serial bit |
| bit_in | input | 1 | Serial input bit valid with bit_stb |
| so_bit | output | 1 | Serial output bit, valid before the next strobe |
| so_oe | output | 1 | Serial output enable |
| ram_addr | output | 14 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM read data, one cycle after address |
| prot_addr | output | 14 | Address being committed, for the protection check |
| prot_mem_ok | input | 1 | Protection unit allows writing prot_addr |
| prot_sr_ok | input | 1 | Protection unit allows a status write |
| sr_wpen | output | 1 | Stored pin-protect enable bit |
| sr_bp | output | 2 | Stored protection level |

## Verification
The properties assume a well-behaved front end. The chip-select and bit pulses each last one clock and never coincide, bit strobes come only between a fall and the following rise, and at least three idle clocks separate two strobes so that a read fetch can finish. The stimulus keeps to this by driving every pulse for one clock from a negative edge and then waiting three clocks. It also waits one idle clock after each chip-select pulse. The protection answers are combinational functions of prot_addr and of bench controls that change only while chip select is high.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_SRW,
    ST_SRDONE,
    ST_RDF,
    ST_RDL,
    ST_RDOUT,
    ST_SROUT,
    ST_IGN
  } ctl_state_t;

  // low three bits of a command, bits 7..4 must be zero, bit 3 ignored
  localparam logic [2:0] OPL_WE_SET = 3'b110;
  localparam logic [2:0] OPL_WE_CLR = 3'b100;
  localparam logic [2:0] OPL_SR_RD  = 3'b101;
  localparam logic [2:0] OPL_SR_WR  = 3'b001;
  localparam logic [2:0] OPL_ARR_RD = 3'b011;
  localparam logic [2:0] OPL_ARR_WR = 3'b010;

endpackage

// File: rtl/spimem_rx_shift.sv
module spimem_rx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       stb,
  input  logic       din,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic       at_boundary
);

  logic [2:0] cnt_q, cnt_d;
  logic [6:0] sh_q, sh_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (clr) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (stb) begin
      cnt_d = cnt_q + 3'd1;
      sh_d  = {sh_q[5:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign byte_done   = stb && !clr && (cnt_q == 3'd7);
  assign byte_val    = {sh_q, din};
  assign at_boundary = (cnt_q == 3'd0);

endmodule

// File: rtl/spimem_page_buf.sv
module spimem_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [7:0]        rdata,
  output logic              rvalid
);

  localparam int SLOTS = 1 << PAGE_W;

  logic [7:0]       data_q [SLOTS];
  logic [SLOTS-1:0] vld_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = we && (widx == PAGE_W'(g));

    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[g] <= 1'b0;
      else if (clr) vld_q[g] <= 1'b0;
      else if (hit) vld_q[g] <= 1'b1;
    end
  end

  assign rdata  = data_q[ridx];
  assign rvalid = vld_q[ridx];

endmodule

// File: rtl/spimem_wr_engine.sv
module spimem_wr_engine #(
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_mem,
  output logic              busy,
  output logic              done,
  output logic              slot_en,
  output logic [PAGE_W-1:0] slot_idx
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  logic             busy_q, busy_d;
  logic             mem_q, mem_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    mem_d  = mem_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        mem_d  = start_mem;
        cnt_d  = '0;
      end
    end else if (cnt_q == LAST) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mem_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      mem_q  <= mem_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && (cnt_q == LAST);
  assign slot_en  = busy_q && mem_q && (32'(cnt_q) < PAGE_BYTES);
  assign slot_idx = cnt_q[PAGE_W-1:0];

endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl #(
  parameter int ADDR_W       = 14,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic              so_bit,
  output logic              so_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_we,
  input  logic [7:0]        ram_rdata,
  output logic [ADDR_W-1:0] prot_addr,
  input  logic              prot_mem_ok,
  input  logic              prot_sr_ok,
  output logic              sr_wpen,
  output logic [1:0]        sr_bp
);
  import spimem_pkg::*;

  localparam int HI_W = ADDR_W - 8;
  localparam int PG_W = ADDR_W - PAGE_W;

  ctl_state_t        state_q, state_d;
  logic              wel_q, wel_d;
  logic              wpen_q, wpen_d;
  logic [1:0]        bp_q, bp_d;
  logic              hi_seen_q, hi_seen_d;
  logic [HI_W-1:0]   addr_hi_q, addr_hi_d;
  logic              is_wr_q, is_wr_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [PAGE_W-1:0] wr_off_q, wr_off_d;
  logic              have_data_q, have_data_d;
  logic [7:0]        out_sr_q, out_sr_d;
  logic              oe_q, oe_d;
  logic [2:0]        sr_new_q, sr_new_d;

  logic              rx_done, rx_boundary;
  logic [7:0]        rx_byte;
  logic              buf_clr, buf_we;
  logic [7:0]        buf_rdata;
  logic              buf_rvalid;
  logic              start_mem, start_sr;
  logic              eng_busy, eng_done, eng_slot;
  logic [PAGE_W-1:0] eng_idx;
  logic [7:0]        status_byte;
  logic [ADDR_W-1:0] full_addr;
  logic              opc_valid;

  spimem_rx_shift u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (cs_fall),
    .stb         (bit_stb),
    .din         (bit_in),
    .byte_done   (rx_done),
    .byte_val    (rx_byte),
    .at_boundary (rx_boundary)
  );

  spimem_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (buf_clr),
    .we     (buf_we),
    .widx   (wr_off_q),
    .wdata  (rx_byte),
    .ridx   (eng_idx),
    .rdata  (buf_rdata),
    .rvalid (buf_rvalid)
  );

  spimem_wr_engine #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_mem || start_sr),
    .start_mem (start_mem),
    .busy      (eng_busy),
    .done      (eng_done),
    .slot_en   (eng_slot),
    .slot_idx  (eng_idx)
  );

  assign status_byte = eng_busy ? 8'hFF : {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
  assign full_addr   = {addr_hi_q, rx_byte};
  assign opc_valid   = (rx_byte[7:4] == 4'h0);

  always_comb begin
    state_d     = state_q;
    wel_d       = wel_q;
    wpen_d      = wpen_q;
    bp_d        = bp_q;
    hi_seen_d   = hi_seen_q;
    addr_hi_d   = addr_hi_q;
    is_wr_d     = is_wr_q;
    rd_addr_d   = rd_addr_q;
    page_d      = page_q;
    wr_off_d    = wr_off_q;
    have_data_d = have_data_q;
    out_sr_d    = out_sr_q;
    oe_d        = oe_q;
    sr_new_d    = sr_new_q;
    buf_clr     = 1'b0;
    buf_we      = 1'b0;
    start_mem   = 1'b0;
    start_sr    = 1'b0;

    if (cs_fall) begin
      state_d   = ST_OPC;
      oe_d      = 1'b0;
      hi_seen_d = 1'b0;
    end else if (cs_rise) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      if (rx_boundary && wel_q && !eng_busy) begin
        if (state_q == ST_WDATA && have_data_q) begin
          start_mem = 1'b1;
        end
        if (state_q == ST_SRDONE && prot_sr_ok) begin
          start_sr = 1'b1;
          wpen_d   = sr_new_q[2];
          bp_d     = sr_new_q[1:0];
        end
      end
    end else begin
      unique case (state_q)
        ST_OPC: begin
          if (rx_done) begin
            state_d = ST_IGN;
            if (opc_valid) begin
              unique case (rx_byte[2:0])
                OPL_WE_SET: if (!eng_busy) wel_d = 1'b1;
                OPL_WE_CLR: if (!eng_busy) wel_d = 1'b0;
                OPL_SR_RD: begin
                  out_sr_d = status_byte;
                  oe_d     = 1'b1;
                  state_d  = ST_SROUT;
                end
                OPL_SR_WR:  if (!eng_busy) state_d = ST_SRW;
                OPL_ARR_RD: if (!eng_busy) begin
                  state_d = ST_ADDR;
                  is_wr_d = 1'b0;
                end
                OPL_ARR_WR: if (!eng_busy) begin
                  state_d = ST_ADDR;
                  is_wr_d = 1'b1;
                end
                default: state_d = ST_IGN;
              endcase
            end
          end
        end
        ST_ADDR: begin
          if (rx_done) begin
            if (!hi_seen_q) begin
              hi_seen_d = 1'b1;
              addr_hi_d = rx_byte[HI_W-1:0];
            end else if (is_wr_q) begin
              page_d      = full_addr[ADDR_W-1:PAGE_W];
              wr_off_d    = full_addr[PAGE_W-1:0];
              have_data_d = 1'b0;
              buf_clr     = 1'b1;
              state_d     = ST_WDATA;
            end else begin
              rd_addr_d = full_addr;
              state_d   = ST_RDF;
            end
          end
        end
        ST_WDATA: begin
          if (rx_done) begin
            buf_we      = 1'b1;
            wr_off_d    = wr_off_q + 1'b1;
            have_data_d = 1'b1;
          end
        end
        ST_SRW: begin
          if (rx_done) begin
            sr_new_d = {rx_byte[7], rx_byte[3:2]};
            state_d  = ST_SRDONE;
          end
        end
        ST_RDF: state_d = ST_RDL;
        ST_RDL: begin
          out_sr_d  = ram_rdata;
          oe_d      = 1'b1;
          rd_addr_d = rd_addr_q + 1'b1;
          state_d   = ST_RDOUT;
        end
        ST_RDOUT: begin
          if (bit_stb) begin
            out_sr_d = {out_sr_q[6:0], 1'b0};
            if (rx_done) state_d = ST_RDF;
          end
        end
        ST_SROUT: begin
          if (bit_stb) begin
            out_sr_d = rx_done ? status_byte : {out_sr_q[6:0], 1'b0};
          end
        end
        default: ;
      endcase
    end

    if (eng_done) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wel_q       <= 1'b0;
      wpen_q      <= 1'b0;
      bp_q        <= 2'b00;
      hi_seen_q   <= 1'b0;
      addr_hi_q   <= '0;
      is_wr_q     <= 1'b0;
      rd_addr_q   <= '0;
      page_q      <= '0;
      wr_off_q    <= '0;
      have_data_q <= 1'b0;
      out_sr_q    <= '0;
      oe_q        <= 1'b0;
      sr_new_q    <= '0;
    end else begin
      state_q     <= state_d;
      wel_q       <= wel_d;
      wpen_q      <= wpen_d;
      bp_q        <= bp_d;
      hi_seen_q   <= hi_seen_d;
      addr_hi_q   <= addr_hi_d;
      is_wr_q     <= is_wr_d;
      rd_addr_q   <= rd_addr_d;
      page_q      <= page_d;
      wr_off_q    <= wr_off_d;
      have_data_q <= have_data_d;
      out_sr_q    <= out_sr_d;
      oe_q        <= oe_d;
      sr_new_q    <= sr_new_d;
    end
  end

  assign so_bit    = out_sr_q[7];
  assign so_oe     = oe_q;
  assign prot_addr = {page_q, eng_idx};
  assign ram_addr  = eng_busy ? {page_q, eng_idx} : rd_addr_q;
  assign ram_wdata = buf_rdata;
  assign ram_we    = eng_slot && buf_rvalid && prot_mem_ok;
  assign sr_wpen   = wpen_q;
  assign sr_bp     = bp_q;

endmodule

// File: rtl/spimem_ctrl_chk.sv
module spimem_ctrl_chk #(
  parameter int PG_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_rise,
  input logic                    so_oe,
  input logic                    eng_busy,
  input logic                    wel_q,
  input logic [PG_W-1:0]         page_q,
  input spimem_pkg::ctl_state_t  state_q
);
  import spimem_pkg::*;

  // R3: an ignored command never drives the output
  a_r3_ign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGN) |-> !so_oe);

  // R12: output released after every chip-select rise
  a_r12_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe);

  // R7: a write cycle only begins right after a chip-select rise
  a_r7_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(cs_rise));

  // R10: the write-enable latch is clear once a write cycle ends
  a_r10_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |-> !wel_q);

  // R6: the committed page does not move during a write cycle
  a_r6_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> $stable(page_q));

  // R9: no array read streams while busy
  a_r9_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> (state_q != ST_RDOUT));

endmodule

bind spimem_ctrl spimem_ctrl_chk #(.PG_W(ADDR_W - PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_rise  (cs_rise),
  .so_oe    (so_oe),
  .eng_busy (eng_busy),
  .wel_q    (wel_q),
  .page_q   (page_q),
  .state_q  (state_q)
);

// File: tb/test_spimem_ctrl.sv
module test_spimem_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int WCYC = 200;

  logic clk, rst_n;
  logic cs_fall, cs_rise, bit_stb, bit_in;
  logic so_bit, so_oe;
  logic [AW-1:0] ram_addr, prot_addr;
  logic [7:0] ram_wdata, ram_rdata;
  logic ram_we, prot_mem_ok, prot_sr_ok, sr_wpen;
  logic [1:0] sr_bp;
  logic lock_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];
  logic [7:0] mem [int];

  spimem_ctrl #(.ADDR_W(AW), .PAGE_W(6), .WRITE_CYCLES(WCYC)) i_spimem_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .bit_stb(bit_stb), .bit_in(bit_in), .so_bit(so_bit), .so_oe(so_oe),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .prot_addr(prot_addr), .prot_mem_ok(prot_mem_ok),
    .prot_sr_ok(prot_sr_ok), .sr_wpen(sr_wpen), .sr_bp(sr_bp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // RAM model and protection model
  always @(posedge clk) begin
    if (ram_we) mem[int'(ram_addr)] = ram_wdata;
    ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
  end
  assign prot_mem_ok = !(lock_hi && (prot_addr >= 14'h3000));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: pops expected items as results arrive
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  task automatic expect_byte(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic xfer(input logic b, output logic o);
    o = so_bit;
    bit_in = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic o;
    for (int i = 7; i >= 0; i--) xfer(v[i], o);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic o;
      xfer(1'b0, o);
      v[i] = o;
    end
  endtask

  task automatic sel_begin();
    cs_fall = 1'b1;
    @(negedge clk);
    cs_fall = 1'b0;
    @(negedge clk);
  endtask

  task automatic sel_end();
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] v);
    sel_begin();
    send_byte(8'h05);
    recv_byte(v);
    sel_end();
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel_begin();
    send_byte(op);
    sel_end();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'hFF;
    while (s[0]) read_status(s);
  endtask

  task automatic write_bytes(input logic [15:0] a, input logic [7:0] d0, input int n,
                             input logic [7:0] d1, input logic [7:0] d2);
    sel_begin();
    send_byte(8'h02);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    send_byte(d0);
    if (n > 1) send_byte(d1);
    if (n > 2) send_byte(d2);
    sel_end();
  endtask

  task automatic read_stream(input logic [7:0] op, input logic [15:0] a, input int n);
    sel_begin();
    send_byte(op);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      recv_byte(v);
      got_q.push_back(v);
    end
    sel_end();
  endtask

  task automatic status_expect(input logic [7:0] e, input string t);
    logic [7:0] s;
    expect_byte(e, t);
    read_status(s);
    got_q.push_back(s);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual 00 expected 01");
    finish_run();
  end

  initial begin
    logic [7:0] s;
    logic o;
    rst_n = 1'b0;
    cs_fall = 0; cs_rise = 0; bit_stb = 0; bit_in = 0;
    lock_hi = 0; prot_sr_ok = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R10 reset state
    check(so_oe == 1'b0, "R12 reset so_oe", {7'd0, so_oe}, 8'h00);
    status_expect(8'h00, "R10 reset status");

    // R1 bit 3 ignored, set and clear write enable
    cmd1(8'h0E);
    status_expect(8'h02, "R1 set-enable with bit3");
    cmd1(8'h04);
    status_expect(8'h00, "R1 clear-enable");

    // R4/R2/R10 write with don't-care high address bits
    cmd1(8'h06);
    write_bytes(16'hC105, 8'hAA, 2, 8'h55, 8'h00);
    status_expect(8'hFF, "R2 busy status");
    // R9 read ignored while busy
    sel_begin();
    send_byte(8'h03);
    send_byte(8'h00);
    send_byte(8'h00);
    xfer(1'b0, o);
    check(so_oe == 1'b0, "R9 read while busy", {7'd0, so_oe}, 8'h00);
    sel_end();
    wait_idle();
    status_expect(8'h00, "R10 enable cleared after cycle");
    expect_byte(8'hAA, "R4 first byte");
    expect_byte(8'h55, "R5 increment");
    read_stream(8'h0B, 16'h0105, 2);

    // R6 page wrap
    cmd1(8'h06);
    write_bytes(16'h013E, 8'h11, 3, 8'h22, 8'h33);
    wait_idle();
    expect_byte(8'h33, "R6 wrapped byte");
    read_stream(8'h03, 16'h0100, 1);
    expect_byte(8'h11, "R6 page byte 3E");
    expect_byte(8'h22, "R6 page byte 3F");
    expect_byte(8'h00, "R6 next page untouched");
    read_stream(8'h03, 16'h013E, 3);

    // R5 whole-array wrap
    cmd1(8'h06);
    write_bytes(16'h3FFF, 8'h77, 1, 8'h00, 8'h00);
    wait_idle();
    cmd1(8'h06);
    write_bytes(16'h0000, 8'h88, 1, 8'h00, 8'h00);
    wait_idle();
    expect_byte(8'h77, "R5 top byte");
    expect_byte(8'h88, "R5 wrap to zero");
    read_stream(8'h03, 16'h3FFF, 2);

    // R7 write without enable discarded
    write_bytes(16'h0200, 8'h99, 1, 8'h00, 8'h00);
    status_expect(8'h00, "R7 no busy without enable");
    expect_byte(8'h00, "R7 array unchanged");
    read_stream(8'h03, 16'h0200, 1);

    // R8 mid-byte abort
    cmd1(8'h06);
    sel_begin();
    send_byte(8'h02);
    send_byte(8'h02);
    send_byte(8'h10);
    send_byte(8'h5A);
    xfer(1'b1, o);
    xfer(1'b0, o);
    xfer(1'b1, o);
    sel_end();
    status_expect(8'h02, "R8 abort keeps enable, not busy");
    expect_byte(8'h00, "R8 nothing programmed");
    read_stream(8'h03, 16'h0210, 1);

    // R3 unknown command, later bits ignored
    cmd1(8'h04);
    sel_begin();
    send_byte(8'h85);
    send_byte(8'h06);
    check(so_oe == 1'b0, "R3 output stays off", {7'd0, so_oe}, 8'h00);
    sel_end();
    status_expect(8'h00, "R3 trailing enable ignored");

    // R2 status write
    cmd1(8'h06);
    sel_begin();
    send_byte(8'h01);
    send_byte(8'hFC);
    sel_end();
    wait_idle();
    status_expect(8'h8C, "R2 status layout");
    check({sr_wpen, sr_bp} == 3'b111, "R2 status ports", {5'd0, sr_wpen, sr_bp}, 8'h07);

    // R11 status write refused
    prot_sr_ok = 0;
    cmd1(8'h06);
    sel_begin();
    send_byte(8'h01);
    send_byte(8'h00);
    sel_end();
    status_expect(8'h8E, "R11 refused status write");
    prot_sr_ok = 1;

    // R11 array protection
    lock_hi = 1;
    write_bytes(16'h3000, 8'h12, 1, 8'h00, 8'h00);
    wait_idle();
    expect_byte(8'h00, "R11 protected byte kept");
    read_stream(8'h03, 16'h3000, 1);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end

endmodule